// File: doc/BRIEF.md
# GPIO Port with Peripheral Override

This block is a six-pin general-purpose I/O port slice behind a small register bus. Five pins are bidirectional: each has a stored direction bit and an output data latch bit, and software reads and writes both. The sixth pin is input-only. A configuration input decides whether that pin is an active-low master reset request or an ordinary digital input. All pin levels pass through a two-flop synchroniser before software or the reset path sees them.

Each bidirectional pin can be taken over by an on-chip peripheral. While the peripheral's select for that pin is high, the peripheral supplies the pad output enable and the pad output data. The stored direction and latch bits are left untouched, so a read-modify-write of the direction register stays safe while an override is active. Reading the latch register returns the stored output values. Reading the port register returns the synchronised pin levels. The pads use separate output-data, output-enable and input signals, so no tri-state net is needed.

Top module: `gpio_ovr_port`

## Requirements
- R1: While reset is asserted, and afterwards until the first write, the direction register (address 2) reads 0x1F, the latch register (address 1) reads 0x00 and every pad_oe bit is 0.
- R2: For a pin whose periph_sel bit is 0, pad_oe is the inverse of its direction bit (1 = input, driver off), and pad_out equals its latch bit.
- R3: A read of address 1 returns the latch in bits 4:0 and 0 in bits 7:5, whatever the pad levels are.
- R4: A read of address 0 returns pad_in[4:0] in bits 4:0 and 0 in bits 7:6. A pad change made before a rising edge is not yet visible after that edge and is visible after the second edge.
- R5: A write to address 0 or address 1 loads reg_wdata[4:0] into the latch on the rising edge. Bits 7:5 of the write data have no effect.
- R6: A write to address 2 loads reg_wdata[4:0] into the direction register on the rising edge.
- R7: For a pin whose periph_sel bit is 1, pad_oe equals its periph_oe bit and pad_out equals its periph_do bit, and the direction register read value does not change.
- R8: With cfg_rst_en = 1, mrst_req goes to 1 on the third rising edge after pad_in[5] falls low (two synchroniser edges and one output register edge), and bit 5 of an address-0 read is 0.
- R9: With cfg_rst_en = 0, mrst_req is 0 one edge later and stays 0, and bit 5 of an address-0 read is the synchronised pad_in[5].
- R10: Address 3 reads 0x00, and a write to it changes neither the latch nor the direction register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset; release is synchronised inside |
| reg_addr | input | 2 | Register address (0 port, 1 latch, 2 direction, 3 unused) |
| reg_wr | input | 1 | Write strobe, sampled on the rising edge |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for reg_addr, combinational |
| cfg_rst_en | input | 1 | 1: pin 5 is a master reset input; 0: plain digital input |
| periph_sel | input | 5 | Per-pin peripheral takeover select |
| periph_oe | input | 5 | Peripheral output enable, active high |
| periph_do | input | 5 | Peripheral output data |
| pad_in | input | 6 | Pad input levels, asynchronous |
| pad_out | output | 5 | Pad output data |
| pad_oe | output | 5 | Pad output enable, active high |
| mrst_req | output | 1 | Registered master reset request, active high |

## Verification
The register assertions assume that reg_addr, reg_wr and reg_wdata are stable around each rising edge. The reset-request assertion assumes that cfg_rst_en changes only with the clock. The bench changes every bus, configuration and peripheral input on the falling edge, so each input is settled a half period before the edge that samples it. Pad inputs are asynchronous by nature. The bench still changes them on the falling edge, so the two-edge synchroniser latency is exact and can be checked to the cycle.

// File: rtl/gpio_ovr_pkg.sv
package gpio_ovr_pkg;
  typedef enum logic [1:0] {
    RA_PORT = 2'd0,
    RA_LAT  = 2'd1,
    RA_DIR  = 2'd2,
    RA_NONE = 2'd3
  } reg_addr_e;
endpackage

// File: rtl/gpio_rst_sync.sv
module gpio_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n_a,
  output logic rst_n_o
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n_a) begin
    if (!rst_n_a) chain_q <= '0;
    else          chain_q <= chain_d;
  end

  assign rst_n_o = chain_q[STAGES-1];
endmodule

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
  parameter int               WIDTH   = 6,
  parameter int               STAGES  = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [STAGES-1:0][WIDTH-1:0] stg_q;
  logic [STAGES-1:0][WIDTH-1:0] stg_d;

  always_comb begin
    stg_d[0] = d;
    for (int k = 1; k < STAGES; k++) stg_d[k] = stg_q[k-1];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stg_q <= {STAGES{RST_VAL}};
    else        stg_q <= stg_d;
  end

  assign q = stg_q[STAGES-1];
endmodule

// File: rtl/gpio_regs.sv
module gpio_regs
  import gpio_ovr_pkg::*;
#(
  parameter int NUM_IO = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  reg_addr_e         addr,
  input  logic [NUM_IO-1:0] wdata,
  output logic [NUM_IO-1:0] lat_q,
  output logic [NUM_IO-1:0] dir_q
);
  logic [NUM_IO-1:0] lat_d, dir_d;
  logic              lat_en, dir_en;

  always_comb begin
    lat_en = wr_en && (addr == RA_PORT || addr == RA_LAT);
    dir_en = wr_en && (addr == RA_DIR);
    lat_d  = lat_q;
    dir_d  = dir_q;
    if (lat_en) lat_d = wdata;
    if (dir_en) dir_d = wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lat_q <= '0;
      dir_q <= '1;
    end else begin
      if (lat_en) lat_q <= lat_d;
      if (dir_en) dir_q <= dir_d;
    end
  end

  assert_latch_write_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && (addr == RA_PORT || addr == RA_LAT)) |=> lat_q == $past(wdata));

  assert_dir_write_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == RA_DIR) |=> dir_q == $past(wdata));

  // R7 and R10: only an explicit direction write moves the direction bits
  assert_dir_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en && addr == RA_DIR) |=> $stable(dir_q));

  assert_latch_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en && (addr == RA_PORT || addr == RA_LAT)) |=> $stable(lat_q));
endmodule

// File: rtl/gpio_pin_mux.sv
module gpio_pin_mux #(
  parameter int NUM_IO = 5
) (
  input  logic [NUM_IO-1:0] dir_q,
  input  logic [NUM_IO-1:0] lat_q,
  input  logic [NUM_IO-1:0] periph_sel,
  input  logic [NUM_IO-1:0] periph_oe,
  input  logic [NUM_IO-1:0] periph_do,
  output logic [NUM_IO-1:0] pad_oe,
  output logic [NUM_IO-1:0] pad_out
);
  for (genvar i = 0; i < NUM_IO; i++) begin : g_pin
    assign pad_oe[i]  = periph_sel[i] ? periph_oe[i] : ~dir_q[i];
    assign pad_out[i] = periph_sel[i] ? periph_do[i] : lat_q[i];
  end
endmodule

// File: rtl/gpio_ovr_port.sv
module gpio_ovr_port
  import gpio_ovr_pkg::*;
#(
  parameter int NUM_IO      = 5,
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        reg_addr,
  input  logic              reg_wr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  input  logic              cfg_rst_en,
  input  logic [NUM_IO-1:0] periph_sel,
  input  logic [NUM_IO-1:0] periph_oe,
  input  logic [NUM_IO-1:0] periph_do,
  input  logic [NUM_IO:0]   pad_in,
  output logic [NUM_IO-1:0] pad_out,
  output logic [NUM_IO-1:0] pad_oe,
  output logic              mrst_req
);
  localparam int        PIN_W  = NUM_IO + 1;
  localparam int        IN_PIN = NUM_IO;
  localparam logic [PIN_W-1:0] SYNC_RST = PIN_W'(1) << IN_PIN;

  logic              rst_n_s;
  logic [PIN_W-1:0]  pin_s;
  logic [NUM_IO-1:0] lat_q, dir_q;
  logic              mrst_d, mrst_q;
  logic              unused_wdata;
  reg_addr_e         addr_e;

  assign addr_e       = reg_addr_e'(reg_addr);
  assign unused_wdata = ^reg_wdata[DATA_W-1:NUM_IO];

  gpio_rst_sync #(.STAGES(SYNC_STAGES)) u_rst_sync (
    .clk(clk), .rst_n_a(rst_n), .rst_n_o(rst_n_s)
  );

  gpio_in_sync #(.WIDTH(PIN_W), .STAGES(SYNC_STAGES), .RST_VAL(SYNC_RST)) u_in_sync (
    .clk(clk), .rst_n(rst_n_s), .d(pad_in), .q(pin_s)
  );

  gpio_regs #(.NUM_IO(NUM_IO)) u_regs (
    .clk(clk), .rst_n(rst_n_s), .wr_en(reg_wr), .addr(addr_e),
    .wdata(reg_wdata[NUM_IO-1:0]), .lat_q(lat_q), .dir_q(dir_q)
  );

  gpio_pin_mux #(.NUM_IO(NUM_IO)) u_pin_mux (
    .dir_q(dir_q), .lat_q(lat_q), .periph_sel(periph_sel),
    .periph_oe(periph_oe), .periph_do(periph_do),
    .pad_oe(pad_oe), .pad_out(pad_out)
  );

  always_comb begin
    reg_rdata = '0;
    unique case (addr_e)
      RA_PORT: begin
        reg_rdata[NUM_IO-1:0] = pin_s[NUM_IO-1:0];
        reg_rdata[IN_PIN]     = ~cfg_rst_en & pin_s[IN_PIN];
      end
      RA_LAT:  reg_rdata[NUM_IO-1:0] = lat_q;
      RA_DIR:  reg_rdata[NUM_IO-1:0] = dir_q;
      default: reg_rdata = '0;
    endcase
  end

  always_comb begin
    mrst_d = cfg_rst_en & ~pin_s[IN_PIN];
  end

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) mrst_q <= 1'b0;
    else          mrst_q <= mrst_d;
  end

  assign mrst_req = mrst_q;

  assert_no_rst_req_R9: assert property (@(posedge clk) disable iff (!rst_n_s)
    !cfg_rst_en |=> !mrst_req);

  assert_rst_req_R8: assert property (@(posedge clk) disable iff (!rst_n_s)
    (cfg_rst_en && !pin_s[IN_PIN]) |=> mrst_req);
endmodule

// File: tb/gpio_ovr_port_tb.sv
module gpio_ovr_port_tb;
  logic       clk = 1'b0;
  logic       rst_n;
  logic [1:0] reg_addr;
  logic       reg_wr;
  logic [7:0] reg_wdata;
  logic [7:0] reg_rdata;
  logic       cfg_rst_en;
  logic [4:0] periph_sel, periph_oe, periph_do;
  logic [5:0] pad_in;
  logic [4:0] pad_out, pad_oe;
  logic       mrst_req;

  always #5 clk = ~clk;

  gpio_ovr_port u_dut (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .cfg_rst_en(cfg_rst_en),
    .periph_sel(periph_sel), .periph_oe(periph_oe), .periph_do(periph_do),
    .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe), .mrst_req(mrst_req)
  );

  typedef struct {
    int         kind;   // 0 rdata, 1 pad_oe, 2 pad_out, 3 mrst_req
    logic [7:0] exp;
    string      tag;
  } item_t;

  item_t sb_q[$];
  event  chk_ev;
  int    n_chk  = 0;
  int    n_fail = 0;
  bit    done   = 0;

  initial begin
    forever begin
      @(chk_ev);
      while (sb_q.size() > 0) begin
        item_t it;
        logic [7:0] act;
        it = sb_q.pop_front();
        case (it.kind)
          0:       act = reg_rdata;
          1:       act = {3'b0, pad_oe};
          2:       act = {3'b0, pad_out};
          default: act = {7'b0, mrst_req};
        endcase
        n_chk++;
        if (act !== it.exp) begin
          n_fail++;
          $display("FAIL %s: actual 0x%02h expected 0x%02h", it.tag, act, it.exp);
        end
      end
    end
  end

  task automatic chk(input int kind, input logic [1:0] a, input logic [7:0] exp, input string tag);
    item_t it;
    reg_addr = a;
    #1;
    it.kind = kind; it.exp = exp; it.tag = tag;
    sb_q.push_back(it);
    ->chk_ev;
    #1;
  endtask

  task automatic wr_reg(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic cycles(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; reg_addr = 2'd0; reg_wr = 1'b0; reg_wdata = 8'h00;
    cfg_rst_en = 1'b0; periph_sel = '0; periph_oe = '0; periph_do = '0;
    pad_in = 6'b111111;
    cycles(3);
    rst_n = 1'b1;
    cycles(5);

    // R1 reset state
    chk(0, 2'd2, 8'h1F, "R1 dir after reset");
    chk(0, 2'd1, 8'h00, "R1 latch after reset");
    chk(1, 2'd0, 8'h00, "R1 pad_oe after reset");

    // R4 latency and R9 pin5 readable
    chk(0, 2'd0, 8'h3F, "R9 port read pin5 high");
    @(negedge clk); pad_in = 6'b101010;
    @(negedge clk);
    chk(0, 2'd0, 8'h3F, "R4 not visible after one edge");
    @(negedge clk);
    chk(0, 2'd0, 8'h2A, "R4 visible after two edges");

    // R5 latch write via address 1, upper bits ignored; R3 latch read
    wr_reg(2'd1, 8'hF5);
    chk(0, 2'd1, 8'h15, "R5 latch write upper bits ignored");
    chk(0, 2'd0, 8'h2A, "R3 port read unaffected by latch");

    // R6 direction write; R2 muxing
    wr_reg(2'd2, 8'hE0);
    chk(0, 2'd2, 8'h00, "R6 dir write");
    chk(1, 2'd0, 8'h1F, "R2 all outputs enabled");
    chk(2, 2'd0, 8'h15, "R2 pad_out follows latch");

    // R5 write through port address
    wr_reg(2'd0, 8'h0A);
    chk(0, 2'd1, 8'h0A, "R5 port write loads latch");
    chk(2, 2'd0, 8'h0A, "R5 pad_out after port write");
    chk(0, 2'd1, 8'h0A, "R3 latch read ignores pads");

    wr_reg(2'd2, 8'h0C);
    chk(1, 2'd0, 8'h13, "R2 mixed direction");

    // R7 peripheral override on pins 0 and 2
    @(negedge clk);
    periph_sel = 5'b00101; periph_oe = 5'b00100; periph_do = 5'b11111;
    chk(1, 2'd0, 8'h16, "R7 pad_oe under override");
    chk(2, 2'd0, 8'h0F, "R7 pad_out under override");
    cycles(2);
    chk(0, 2'd2, 8'h0C, "R7 dir unchanged under override");
    @(negedge clk);
    periph_sel = '0;
    chk(1, 2'd0, 8'h13, "R2 direction back after override");

    // R10 unused address
    chk(0, 2'd3, 8'h00, "R10 address 3 reads zero");
    wr_reg(2'd3, 8'hFF);
    chk(0, 2'd2, 8'h0C, "R10 dir unchanged by address 3");
    chk(0, 2'd1, 8'h0A, "R10 latch unchanged by address 3");

    // R8 reset mode
    @(negedge clk); cfg_rst_en = 1'b1;
    chk(0, 2'd0, 8'h0A, "R8 pin5 reads zero in reset mode");
    @(negedge clk);
    chk(3, 2'd0, 8'h00, "R8 no request while pin high");
    pad_in[5] = 1'b0;
    cycles(2);
    chk(3, 2'd0, 8'h00, "R8 request not yet after two edges");
    @(negedge clk);
    chk(3, 2'd0, 8'h01, "R8 request after third edge");

    // R9 input mode clears request
    cfg_rst_en = 1'b0;
    @(negedge clk);
    chk(3, 2'd0, 8'h00, "R9 request cleared in input mode");
    cycles(3);
    chk(3, 2'd0, 8'h00, "R9 request stays low");
    chk(0, 2'd0, 8'h0A, "R9 pin5 low read");

    // R1 asynchronous reset mid run
    @(negedge clk); rst_n = 1'b0;
    chk(0, 2'd2, 8'h1F, "R1 dir during reset");
    chk(1, 2'd0, 8'h00, "R1 pad_oe during reset");
    chk(0, 2'd1, 8'h00, "R1 latch during reset");

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule